// File: doc/BRIEF.md
# Masked Four-Input Pipelined Summing Tree

This block adds together the power, real and imaginary terms of four antenna inputs and produces one combined result for each term. Every antenna carries an unsigned 6-bit power value and two 5-bit two's-complement values, one real and one imaginary. The block adds them in a binary tree with two levels. Level one adds antennas 0 and 1, and also antennas 2 and 3. Level two adds the two partial sums.

At the front of the tree, each antenna's terms are captured in registers that can be cleared. Two enable masks with one bit per antenna control the clearing. The first mask gates the power path and the second gates the real and imaginary paths together. Any subset of antennas can therefore take part in each sum. A valid flag travels through the pipeline next to the data.

Each stage is registered: the input capture, the level-one sums and the level-two sums. A result appears three clock edges after its inputs and masks are sampled. A new set of inputs can be accepted on every cycle.

Top module: `dish_sum_tree`

## Requirements
- R1: While `rst_n` is low, and after it is released until new data arrives, `out_valid` is 0 and all three sums are 0.
- R2: The values of `in_valid`, the inputs and the masks that are sampled at clock edge k appear on `out_valid` and on the sums right after edge k+2. That is three register stages.
- R3: `pwr_sum` is the unsigned 8-bit sum of the enabled antennas' 6-bit power fields. Antenna d's power field is `pwr_in[6d+5:6d]`.
- R4: `re_sum` and `im_sum` are the 7-bit two's-complement sums of the enabled antennas' 5-bit two's-complement fields. Antenna d's fields are `re_in[5d+4:5d]` and `im_in[5d+4:5d]`.
- R5: When `pwr_mask[d]` is 0, antenna d contributes zero to `pwr_sum`. This bit has no effect on `re_sum` or `im_sum`.
- R6: When `ri_mask[d]` is 0, antenna d contributes zero to both `re_sum` and `im_sum`. This bit has no effect on `pwr_sum`.
- R7: Each mask applies to the data sampled on the same edge. A mask change affects only the results of that sample and later ones.
- R8: The sums at the extremes do not wrap: four power values of 63 give 252, four values of -16 give -64, and four values of +15 give +60.
- R9: Inputs applied on consecutive cycles give results on consecutive cycles, in the same order, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the current input sample as valid |
| pwr_in | input | 24 | Four 6-bit unsigned power fields, antenna 0 in the low bits |
| re_in | input | 20 | Four 5-bit signed real fields, antenna 0 in the low bits |
| im_in | input | 20 | Four 5-bit signed imaginary fields, antenna 0 in the low bits |
| pwr_mask | input | 4 | Power enable per antenna, 1 = include |
| ri_mask | input | 4 | Real/imaginary enable per antenna, 1 = include |
| out_valid | output | 1 | Valid flag delayed by three stages |
| pwr_sum | output | 8 | Unsigned sum of the enabled power fields |
| re_sum | output | 7 | Signed sum of the enabled real fields |
| im_sum | output | 7 | Signed sum of the enabled imaginary fields |

## Verification
A fault in one capture register or one partial-sum register shows up as a wrong value in exactly one of the three sums. It appears three cycles after the sample that exposes it. The cycle in which it appears identifies the sample. Whether the error follows the power mask or the real/imaginary mask shows which capture register is at fault. A fault in sign handling appears only for negative inputs and for cancelling mixes. A fault in pipeline alignment moves a whole result one cycle early or late, so the results of back-to-back samples disagree on every cycle.

// File: rtl/dish_sum_tree.sv
module dish_sum_tree #(
  parameter int PW = 6,
  parameter int IW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4*PW-1:0]   pwr_in,
  input  logic [4*IW-1:0]   re_in,
  input  logic [4*IW-1:0]   im_in,
  input  logic [3:0]        pwr_mask,
  input  logic [3:0]        ri_mask,
  output logic              out_valid,
  output logic [PW+1:0]     pwr_sum,
  output logic [IW+1:0]     re_sum,
  output logic [IW+1:0]     im_sum
);
  localparam int ND = 4;
  localparam int NP = ND / 2;

  logic [PW-1:0] p_q [ND];
  logic [IW-1:0] r_q [ND];
  logic [IW-1:0] i_q [ND];
  logic [PW:0]   p_l1 [NP];
  logic [IW:0]   r_l1 [NP];
  logic [IW:0]   i_l1 [NP];
  logic          v_q, v_l1;

  // Capture stage: a cleared mask bit loads zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      for (int d = 0; d < ND; d++) begin
        p_q[d] <= '0;
        r_q[d] <= '0;
        i_q[d] <= '0;
      end
    end else begin
      v_q <= in_valid;
      for (int d = 0; d < ND; d++) begin
        p_q[d] <= pwr_mask[d] ? pwr_in[d*PW +: PW] : '0;
        r_q[d] <= ri_mask[d]  ? re_in[d*IW +: IW]  : '0;
        i_q[d] <= ri_mask[d]  ? im_in[d*IW +: IW]  : '0;
      end
    end
  end

  // Level one: pairwise sums, one bit wider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_l1 <= 1'b0;
      for (int k = 0; k < NP; k++) begin
        p_l1[k] <= '0;
        r_l1[k] <= '0;
        i_l1[k] <= '0;
      end
    end else begin
      v_l1 <= v_q;
      for (int k = 0; k < NP; k++) begin
        p_l1[k] <= {1'b0, p_q[2*k]} + {1'b0, p_q[2*k+1]};
        r_l1[k] <= {r_q[2*k][IW-1], r_q[2*k]} + {r_q[2*k+1][IW-1], r_q[2*k+1]};
        i_l1[k] <= {i_q[2*k][IW-1], i_q[2*k]} + {i_q[2*k+1][IW-1], i_q[2*k+1]};
      end
    end
  end

  // Level two: final sums
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pwr_sum   <= '0;
      re_sum    <= '0;
      im_sum    <= '0;
    end else begin
      out_valid <= v_l1;
      pwr_sum   <= {1'b0, p_l1[0]} + {1'b0, p_l1[1]};
      re_sum    <= {r_l1[0][IW], r_l1[0]} + {r_l1[1][IW], r_l1[1]};
      im_sum    <= {i_l1[0][IW], i_l1[0]} + {i_l1[1][IW], i_l1[1]};
    end
  end

  AST_VALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##3 out_valid); // R2
  AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |-> ##3 !out_valid); // R9
  AST_PWR_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (pwr_mask == 4'h0) |-> ##3 (pwr_sum == '0)); // R5
  AST_RI_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (ri_mask == 4'h0) |-> ##3 (re_sum == '0 && im_sum == '0)); // R6
  AST_PWR_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (pwr_mask == 4'hF && pwr_in == '1) |-> ##3 (pwr_sum == 8'd252)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_valid && pwr_sum == '0)); // R1
endmodule

// File: tb/dish_sum_tree_tb.sv
module dish_sum_tree_tb;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [23:0] pwr_in = '0;
  logic [19:0] re_in = '0, im_in = '0;
  logic [3:0] pwr_mask = '0, ri_mask = '0;
  logic out_valid;
  logic [7:0] pwr_sum;
  logic [6:0] re_sum, im_sum;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  int    h_v [3], h_p [3], h_r [3], h_i [3];
  string h_t [3];

  always #2 clk = ~clk;

  dish_sum_tree u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pwr_in(pwr_in), .re_in(re_in), .im_in(im_in),
    .pwr_mask(pwr_mask), .ri_mask(ri_mask),
    .out_valid(out_valid), .pwr_sum(pwr_sum), .re_sum(re_sum), .im_sum(im_sum));

  function automatic int f_pwr(logic [23:0] p, logic [3:0] m);
    int s = 0;
    for (int d = 0; d < 4; d++) if (m[d]) s += int'(p[d*6 +: 6]);
    return s;
  endfunction

  function automatic int f_sgn(logic [19:0] x, logic [3:0] m);
    int s = 0;
    for (int d = 0; d < 4; d++) if (m[d]) s += int'($signed(x[d*5 +: 5]));
    return s;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: check output due now, shift history, apply new sample
  task automatic step(string tag, logic v, logic [23:0] p, logic [19:0] r,
                      logic [19:0] i, logic [3:0] pm, logic [3:0] rm);
    @(negedge clk);
    chk(h_t[2], "valid", int'(out_valid), h_v[2]);
    chk(h_t[2], "pwr", int'(pwr_sum), h_p[2]);
    chk(h_t[2], "re", int'($signed(re_sum)), h_r[2]);
    chk(h_t[2], "im", int'($signed(im_sum)), h_i[2]);
    for (int k = 2; k > 0; k--) begin
      h_v[k] = h_v[k-1]; h_p[k] = h_p[k-1]; h_r[k] = h_r[k-1];
      h_i[k] = h_i[k-1]; h_t[k] = h_t[k-1];
    end
    h_v[0] = int'(v); h_p[0] = f_pwr(p, pm);
    h_r[0] = f_sgn(r, rm); h_i[0] = f_sgn(i, rm); h_t[0] = tag;
    in_valid = v; pwr_in = p; re_in = r; im_in = i; pwr_mask = pm; ri_mask = rm;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin
      h_v[k] = 0; h_p[k] = 0; h_r[k] = 0; h_i[k] = 0; h_t[k] = "R1";
    end
    pwr_in = '1; re_in = '1; im_in = '1; pwr_mask = '1; ri_mask = '1; in_valid = 1;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(out_valid), 0);
    chk("R1", "pwr in reset", int'(pwr_sum), 0);
    chk("R1", "re in reset", int'(re_sum), 0);
    in_valid = 0; pwr_in = '0; re_in = '0; im_in = '0;
    @(negedge clk); rst_n = 1;
    // R8 extremes
    step("R8", 1, {4{6'd63}}, {4{5'h10}}, {4{5'h0F}}, 4'hF, 4'hF);
    step("R8", 1, {4{6'd63}}, {4{5'h0F}}, {4{5'h10}}, 4'hF, 4'hF);
    // R2 single pulse surrounded by idle
    step("R2", 0, '0, '0, '0, 4'hF, 4'hF);
    step("R2", 1, {6'd1, 6'd2, 6'd3, 6'd4}, {5'd1, 5'd2, 5'd3, 5'd4}, {5'h1F, 5'h1E, 5'd0, 5'd7}, 4'hF, 4'hF);
    step("R2", 0, '0, '0, '0, 4'hF, 4'hF);
    step("R2", 0, '0, '0, '0, 4'hF, 4'hF);
    // R5 power mask only; R6 ri mask only
    step("R5", 1, {4{6'd50}}, {4{5'd9}}, {4{5'h17}}, 4'b0101, 4'hF);
    step("R5", 1, {4{6'd50}}, {4{5'd9}}, {4{5'h17}}, 4'b0000, 4'hF);
    step("R6", 1, {4{6'd50}}, {4{5'd9}}, {4{5'h17}}, 4'hF, 4'b1010);
    step("R6", 1, {4{6'd50}}, {4{5'd9}}, {4{5'h17}}, 4'hF, 4'b0000);
    // R7 mask changes each cycle with the same data
    for (int m = 0; m < 16; m++)
      step("R7", 1, {6'd7, 6'd13, 6'd29, 6'd41}, {5'h11, 5'd5, 5'h1C, 5'd14}, {5'd3, 5'h18, 5'd11, 5'h1F},
           4'(m), 4'(15 - m));
    // R4 cancelling mix
    step("R4", 1, '0, {5'd15, 5'h11, 5'd8, 5'h18}, {5'h10, 5'd15, 5'd1, 5'h1F}, 4'hF, 4'hF);
    // R3/R9 random back-to-back
    for (int n = 0; n < 400; n++)
      step((n % 2) ? "R3" : "R9", 1'($urandom), 24'($urandom), 20'($urandom), 20'($urandom),
           4'($urandom), 4'($urandom));
    for (int n = 0; n < 200; n++)
      step("R4", 1'($urandom), 24'($urandom), 20'($urandom), 20'($urandom), 4'hF, 4'($urandom));
    for (int n = 0; n < 3; n++) step("R9", 0, '0, '0, '0, 4'h0, 4'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule